// File: doc/BRIEF.md
# Configurable SIMD Vector Lane Unit

This block is the vector half of a small SIMD datapath. It holds a bank of vector registers, each made of `LANES` words of `DW` bits (32 by default), and applies one operation to every word of a register at once. Each cycle the issuing side presents an operation code, two source register numbers, a destination register number, a lane number and a scalar word; when `en` is high the result lands in the destination register at the next rising clock edge.

Besides lane-wise arithmetic and logic, the unit can slide a whole register by one word toward the higher or lower lanes, fill every word of a register from the scalar input, copy one register to another, and deposit the scalar input into one chosen lane. A word of any register can be read out to the scalar side at any time through a combinational read port addressed by the first source number and the lane number.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset every word of every register reads 0 through `scalar_out`.
- R2: Codes 1 (add), 2 (subtract a minus b) and 6 (multiply) write, per lane, the low `DW` bits of the result of words from registers `src_a` and `src_b`; no carry or high bits pass to another lane.
- R3: Codes 3 (AND), 4 (OR) and 5 (XOR) write the bitwise result of the two sources per lane.
- R4: Code 7 shifts each word of `src_a` left by one bit and code 8 shifts it right by one bit, both filling the vacated bit with 0; no bit crosses into a neighbouring lane.
- R5: Code 9 writes lane i+1 of the destination with lane i of `src_a` for every lane, writes lane 0 with 0, and drops the top lane.
- R6: Code 10 writes lane i of the destination with lane i+1 of `src_a`, writes the top lane with 0, and drops lane 0.
- R7: Code 11 writes `scalar_in` into every lane of the destination.
- R8: Code 12 copies register `src_a` unchanged into the destination.
- R9: Code 13 writes `scalar_in` into lane `lane_idx` of the destination and leaves its other lanes unchanged; a `lane_idx` of `LANES` or more writes nothing.
- R10: `scalar_out` shows, without a clock edge, word `lane_idx` of register `src_a`; a `lane_idx` of `LANES` or more reads 0.
- R11: Code 0, codes 14 and 15, and any cycle with `en` low leave all registers unchanged.
- R12: Sources are read before the edge, so a destination equal to a source uses that source's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Apply the operation at the next edge |
| op | input | 4 | Operation code |
| src_a | input | $clog2(NREGS) | First source register; also read-port register |
| src_b | input | $clog2(NREGS) | Second source register |
| dst | input | $clog2(NREGS) | Destination register |
| lane_idx | input | $clog2(LANES)+1 | Lane for the scalar deposit and read port |
| scalar_in | input | DW | Scalar word for broadcast and deposit |
| scalar_out | output | DW | Selected word of register `src_a` |

## Verification
The bench pushes all-ones words through add and a large product through multiply, so a design that let carries or high product bits spill into the next lane, or kept more than the low word, shows a wrong neighbour. Words with both end bits set catch a per-word shift that leaks a bit across lanes or fills with something other than 0, and whole-word slides done in place catch a design that reads the destination after partly updating it or fails to zero the vacated lane. Lane numbers just past the top lane catch a deposit that wraps into lane 0 or a read port that returns a real word instead of 0, and disabled cycles and unused codes catch any stray write.

// File: rtl/vec_lane_unit.sv
module vec_lane_unit #(
  parameter int LANES = 4,
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int RW   = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int LIW  = $clog2(LANES) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [3:0]     op,
  input  logic [RW-1:0]  src_a,
  input  logic [RW-1:0]  src_b,
  input  logic [RW-1:0]  dst,
  input  logic [LIW-1:0] lane_idx,
  input  logic [DW-1:0]  scalar_in,
  output logic [DW-1:0]  scalar_out
);

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_ADD   = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_AND   = 4'd3;
  localparam logic [3:0] OP_OR    = 4'd4;
  localparam logic [3:0] OP_XOR   = 4'd5;
  localparam logic [3:0] OP_MUL   = 4'd6;
  localparam logic [3:0] OP_SHL   = 4'd7;
  localparam logic [3:0] OP_SHR   = 4'd8;
  localparam logic [3:0] OP_WUP   = 4'd9;
  localparam logic [3:0] OP_WDN   = 4'd10;
  localparam logic [3:0] OP_BCAST = 4'd11;
  localparam logic [3:0] OP_COPY  = 4'd12;
  localparam logic [3:0] OP_PUT   = 4'd13;

  logic [DW-1:0] rf [NREGS][LANES];
  logic [DW-1:0] res [LANES];
  logic [LANES-1:0] wr_lane;

  logic full_op;
  assign full_op = (op >= OP_ADD) && (op <= OP_COPY);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] a, b, lower, upper;
    assign a = rf[src_a][g];
    assign b = rf[src_b][g];
    if (g == 0) begin : g_lo
      assign lower = '0;
    end else begin : g_lo
      assign lower = rf[src_a][g-1];
    end
    if (g == LANES - 1) begin : g_hi
      assign upper = '0;
    end else begin : g_hi
      assign upper = rf[src_a][g+1];
    end

    always_comb begin
      case (op)
        OP_ADD:   res[g] = a + b;
        OP_SUB:   res[g] = a - b;
        OP_AND:   res[g] = a & b;
        OP_OR:    res[g] = a | b;
        OP_XOR:   res[g] = a ^ b;
        OP_MUL:   res[g] = a * b;
        OP_SHL:   res[g] = {a[DW-2:0], 1'b0};
        OP_SHR:   res[g] = {1'b0, a[DW-1:1]};
        OP_WUP:   res[g] = lower;
        OP_WDN:   res[g] = upper;
        OP_BCAST: res[g] = scalar_in;
        OP_COPY:  res[g] = a;
        OP_PUT:   res[g] = scalar_in;
        default:  res[g] = a;
      endcase
    end

    assign wr_lane[g] = en && (full_op || (op == OP_PUT && lane_idx == LIW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++)
        for (int l = 0; l < LANES; l++)
          rf[r][l] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (wr_lane[l]) rf[dst][l] <= res[l];
    end
  end

  assign scalar_out = (lane_idx < LIW'(LANES)) ? rf[src_a][lane_idx[LIW-2:0]] : '0;

endmodule

module vec_lane_unit_chk #(
  parameter int LANES = 4,
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int RW   = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int LIW  = $clog2(LANES) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [3:0]     op,
  input logic [RW-1:0]  src_a,
  input logic [RW-1:0]  src_b,
  input logic [RW-1:0]  dst,
  input logic [LIW-1:0] lane_idx,
  input logic [DW-1:0]  scalar_in,
  input logic [DW-1:0]  scalar_out
);

  a_r7_bcast_fills: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 4'd11 |=>
      !(src_a == $past(dst) && lane_idx < LIW'(LANES)) || scalar_out == $past(scalar_in));

  a_r9_put_lane: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 4'd13 && lane_idx < LIW'(LANES) |=>
      !(src_a == $past(dst) && lane_idx == $past(lane_idx)) || scalar_out == $past(scalar_in));

  a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    lane_idx >= LIW'(LANES) |-> scalar_out == '0);

  a_r11_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en || op == 4'd0 || op > 4'd13) && $stable(src_a) && $stable(lane_idx)
      |-> $stable(scalar_out));

endmodule

bind vec_lane_unit vec_lane_unit_chk #(.LANES(LANES), .NREGS(NREGS), .DW(DW)) u_chk (.*);

// File: tb/sim_vec_lane_unit.sv
module sim_vec_lane_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int NREGS = 8;

  logic clk = 0, rst_n = 0, en = 0;
  logic [3:0] op = 0;
  logic [2:0] src_a = 0, src_b = 0, dst = 0;
  logic [2:0] lane_idx = 0;
  logic [31:0] scalar_in = 0;
  logic [31:0] scalar_out;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] m [NREGS][LANES];

  vec_lane_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] lane_model(input logic [3:0] o, input int a, input int b,
                                             input logic [31:0] s, input int l);
    logic [31:0] x, y;
    x = m[a][l]; y = m[b][l];
    case (o)
      1: return x + y;
      2: return x - y;
      3: return x & y;
      4: return x | y;
      5: return x ^ y;
      6: return 32'((64'(x) * 64'(y)) & 64'hFFFF_FFFF);
      7: return x << 1;
      8: return x >> 1;
      9: return (l == 0) ? 32'd0 : m[a][l-1];
      10: return (l == LANES-1) ? 32'd0 : m[a][l+1];
      11: return s;
      12: return x;
      default: return s;
    endcase
  endfunction

  task automatic issue(input logic [3:0] o, input int a, input int b, input int d,
                       input logic [31:0] s, input int l, input bit e = 1);
    logic [31:0] nv [LANES];
    for (int i = 0; i < LANES; i++) nv[i] = lane_model(o, a, b, s, i);
    @(negedge clk);
    en = e; op = o; src_a = 3'(a); src_b = 3'(b); dst = 3'(d);
    scalar_in = s; lane_idx = 3'(l);
    @(posedge clk);
    #1;
    en = 0;
    if (e) begin
      if (o >= 1 && o <= 12)
        for (int i = 0; i < LANES; i++) m[d][i] = nv[i];
      else if (o == 13 && l < LANES)
        m[d][l] = s;
    end
  endtask

  task automatic chk(input int r, input int l, input string req);
    logic [31:0] exp;
    src_a = 3'(r); lane_idx = 3'(l);
    #1;
    exp = (l < LANES) ? m[r][l] : 32'd0;
    tests++;
    if (scalar_out !== exp) begin
      fails++;
      $display("FAIL %s reg %0d lane %0d: got %h expected %h", req, r, l, scalar_out, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int r = 0; r < NREGS; r++)
      for (int l = 0; l < LANES; l++) chk(r, l, req);
  endtask

  task automatic chk_val(input int r, input int l, input logic [31:0] v, input string req);
    src_a = 3'(r); lane_idx = 3'(l);
    #1;
    tests++;
    if (scalar_out !== v) begin
      fails++;
      $display("FAIL %s reg %0d lane %0d: got %h expected %h", req, r, l, scalar_out, v);
    end
  endtask

  initial begin
    for (int r = 0; r < NREGS; r++)
      for (int l = 0; l < LANES; l++) m[r][l] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_all("R1");

    // build distinctive registers
    for (int l = 0; l < LANES; l++) issue(13, 0, 0, 1, 32'hFFFF_FFFF, l);
    issue(11, 0, 0, 2, 32'd1, 0);
    chk_all("R9");
    issue(1, 1, 2, 3, 0, 0);
    for (int l = 0; l < LANES; l++) chk_val(3, l, 32'd0, "R2 add wrap");
    issue(2, 3, 2, 4, 0, 0);
    for (int l = 0; l < LANES; l++) chk_val(4, l, 32'hFFFF_FFFF, "R2 sub wrap");
    issue(11, 0, 0, 5, 32'h0001_0003, 0);
    issue(6, 5, 5, 6, 0, 0);
    for (int l = 0; l < LANES; l++) chk_val(6, l, 32'h0006_0009, "R2 mul low");
    issue(13, 0, 0, 7, 32'h8000_0001, 1);
    issue(13, 0, 0, 7, 32'h8000_0001, 2);
    issue(7, 7, 0, 0, 0, 0);
    chk_val(0, 0, 32'd0, "R4 shl"); chk_val(0, 1, 32'h0000_0002, "R4 shl");
    chk_val(0, 2, 32'h0000_0002, "R4 shl"); chk_val(0, 3, 32'd0, "R4 shl");
    issue(8, 7, 0, 0, 0, 0);
    chk_val(0, 1, 32'h4000_0000, "R4 shr"); chk_val(0, 0, 32'd0, "R4 shr");
    chk_val(0, 2, 32'h4000_0000, "R4 shr");
    for (int l = 0; l < LANES; l++) issue(13, 0, 0, 5, 32'(l + 10), l);
    issue(12, 5, 0, 6, 0, 0);
    chk_all("R8");
    issue(9, 5, 0, 5, 0, 0);
    chk_val(5, 0, 0, "R5 R12"); chk_val(5, 1, 10, "R5 R12");
    chk_val(5, 3, 12, "R5 R12");
    issue(10, 6, 0, 6, 0, 0);
    chk_val(6, 0, 11, "R6 R12"); chk_val(6, 3, 0, "R6 R12");
    chk_val(6, 2, 13, "R6");
    issue(3, 5, 6, 0, 0, 0); chk_all("R3");
    issue(4, 5, 6, 0, 0, 0); chk_all("R3");
    issue(5, 5, 6, 0, 0, 0); chk_all("R3");
    issue(13, 0, 0, 6, 32'hDEAD_BEEF, 4);
    issue(13, 0, 0, 6, 32'hDEAD_BEEF, 7);
    chk_all("R9 out of range");
    for (int l = LANES; l < 8; l++) chk(5, l, "R10");
    issue(1, 1, 1, 2, 0, 0, 0);
    issue(0, 1, 1, 2, 32'h55, 0);
    issue(14, 1, 1, 2, 32'h55, 0);
    issue(15, 1, 1, 2, 32'h55, 1);
    chk_all("R11");
    issue(11, 0, 0, 3, 32'hA5A5_0F0F, 0);
    chk_all("R7");

    for (int n = 0; n < 400; n++) begin
      issue(4'($urandom % 16), int'($urandom % NREGS), int'($urandom % NREGS),
            int'($urandom % NREGS), $urandom, int'($urandom % 8), bit'($urandom % 8 != 0));
      chk(int'($urandom % NREGS), int'($urandom % 8), "R2 R10 random");
      if (n % 20 == 19) chk_all("R11 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule